// File: doc/BRIEF.md
# Pixel Timing and Charge Digitizer

This block is the digital front end of a single detector pixel. It watches the pixel's discriminator output and, depending on the operating mode, records when a hit arrived, how long it stayed above threshold, or how many hits were seen and how long they lasted in total over an exposure window. One set of three registers holds the result in every mode: a 14-bit wide field, a 10-bit narrow field and a 4-bit fine field.

The arrival time has two parts. The coarse part is a shared 14-bit timestamp taken on the system clock. The fine part comes from a 16-slot phase count that stands in for a fast oscillator running at sixteen times the system clock. The discriminator (or a test pulse that replaces it) passes through a two-flop synchronizer before edge detection. The phase and timestamp inputs are delayed by the same two stages, so both line up with the clock edge that first saw the hit.

A finished result is held for a fixed transfer time and then flagged valid. It stays frozen until the reader acknowledges it, and further hits are ignored until then. The acknowledge clears the pixel.

Top module: `pixel_digitizer`

## Requirements
- R1: The hit source is `test_pulse_i` when `test_en_i` is 1 and `disc_i` otherwise. While `mask_i` is 1 the hit source is forced low, so no result is produced. The input that is not selected has no effect.
- R2: In the time modes (`mode_i` 2'b00 and 2'b01), `wide_o` reports the value of `gts_i` at the first clock edge that sampled the hit source high.
- R3: In the time modes, `fine_o` equals 15 minus the `phase_i` value present at that same edge.
- R4: In mode 2'b00, `narrow_o` equals the number of clock edges that sampled the hit source high during the pulse.
- R5: In mode 2'b01, `narrow_o` is 0, while `wide_o` and `fine_o` follow R2 and R3.
- R6: In counting mode (`mode_i[1]` = 1), while `shutter_i` is 1, `narrow_o` counts synchronized rising edges of the hit and `wide_o` counts clock cycles with the synchronized hit high. `fine_o` is 0. Pulses while the shutter is closed are not counted. The result is finished when the shutter closes.
- R7: `narrow_o` saturates at 1023 and the count-mode `wide_o` saturates at 16383. Neither wraps.
- R8: In the time modes, `valid_o` rises on the (DEAD_CYC+3)-th clock edge counted from the first edge that samples the hit source low after the pulse. With the default DEAD_CYC of 19, that is the 22nd edge.
- R9: While a result is pending (transfer time or `valid_o` high), hit edges are ignored. The outputs stay stable until the acknowledge.
- R10: After reset, and on the edge after `ack_i` is seen with `valid_o` high, `valid_o` is 0 and all three fields are 0. A rising hit edge detected at that same acknowledge edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 40 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_i | input | 1 | Discriminator output, asynchronous |
| test_pulse_i | input | 1 | Injected test pulse |
| test_en_i | input | 1 | Selects the test pulse as the hit source |
| mask_i | input | 1 | Disables the pixel |
| phase_i | input | 4 | Fast-oscillator slot (0..15) of the hit within the clock period |
| gts_i | input | 14 | Shared coarse timestamp |
| shutter_i | input | 1 | Exposure window for counting mode |
| mode_i | input | 2 | 00 time+width, 01 time only, 1x count+integrated width |
| ack_i | input | 1 | Readout acknowledge, clears the pixel |
| valid_o | output | 1 | Result ready |
| wide_o | output | 14 | Coarse arrival time or integrated width |
| narrow_o | output | 10 | Pulse width or hit count |
| fine_o | output | 4 | Fine arrival time |

## Verification
The readout acknowledge and the detection of a new synchronized rising edge can fall on the same clock edge. In that case the pixel must clear and drop the new edge, not start a measurement from it. The bench raises the hit two cycles before it asserts the acknowledge, so that the synchronized edge lands exactly on the acknowledge edge. It then keeps the hit high and later releases it. It judges the outcome by the cleared fields and by `valid_o` staying low for the following cycles.

// File: rtl/pixel_digitizer.sv
module pixel_digitizer #(
  parameter int TS_W     = 14,
  parameter int CNT_W    = 10,
  parameter int FINE_W   = 4,
  parameter int DEAD_CYC = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disc_i,
  input  logic              test_pulse_i,
  input  logic              test_en_i,
  input  logic              mask_i,
  input  logic [FINE_W-1:0] phase_i,
  input  logic [TS_W-1:0]   gts_i,
  input  logic              shutter_i,
  input  logic [1:0]        mode_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic [TS_W-1:0]   wide_o,
  output logic [CNT_W-1:0]  narrow_o,
  output logic [FINE_W-1:0] fine_o
);
  localparam int TMR_W = $clog2(DEAD_CYC + 1);
  localparam logic [FINE_W-1:0] FINE_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [TS_W-1:0]   WIDE_MAX = '1;

  typedef enum logic [1:0] {IDLE, MEAS, XFER, DONE} st_t;
  st_t st;

  logic              s1, s2, s3, shut_q;
  logic [FINE_W-1:0] p1, p2;
  logic [TS_W-1:0]   g1, g2;
  logic [TMR_W-1:0]  tmr;
  logic [TS_W-1:0]   wide_q;
  logic [CNT_W-1:0]  narrow_q;
  logic [FINE_W-1:0] fine_q;

  wire hit        = ~mask_i & (test_en_i ? test_pulse_i : disc_i);
  wire rise       = s2 & ~s3;
  wire count_mode = mode_i[1];
  wire tot_mode   = (mode_i == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s1, s2, s3, shut_q} <= '0;
      p1 <= '0; p2 <= '0; g1 <= '0; g2 <= '0;
      st <= IDLE; tmr <= '0;
      wide_q <= '0; narrow_q <= '0; fine_q <= '0;
    end else begin
      s1 <= hit; s2 <= s1; s3 <= s2;
      p1 <= phase_i; p2 <= p1;
      g1 <= gts_i;   g2 <= g1;
      shut_q <= shutter_i;
      case (st)
        IDLE: begin
          if (count_mode) begin
            if (shutter_i) begin
              if (rise && narrow_q != CNT_MAX) narrow_q <= narrow_q + 1'b1;
              if (s2 && wide_q != WIDE_MAX)    wide_q   <= wide_q + 1'b1;
            end else if (shut_q) begin
              st  <= XFER;
              tmr <= '0;
            end
          end else if (rise) begin
            wide_q   <= g2;
            fine_q   <= FINE_MAX - p2;
            narrow_q <= CNT_W'(tot_mode);
            st       <= MEAS;
          end
        end
        MEAS: begin
          if (!s2) begin
            st  <= XFER;
            tmr <= '0;
          end else if (tot_mode && narrow_q != CNT_MAX) begin
            narrow_q <= narrow_q + 1'b1;
          end
        end
        XFER: begin
          if (tmr == TMR_W'(DEAD_CYC - 1)) st <= DONE;
          else tmr <= tmr + 1'b1;
        end
        DONE: begin
          if (ack_i) begin
            st <= IDLE;
            wide_q <= '0; narrow_q <= '0; fine_q <= '0;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign valid_o  = (st == DONE);
  assign wide_o   = wide_q;
  assign narrow_o = narrow_q;
  assign fine_o   = fine_q;

  // R9
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ack_i |=> valid_o && $stable(wide_o) && $stable(narrow_o) && $stable(fine_o));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ack_i |=> !valid_o && wide_o == '0 && narrow_o == '0 && fine_o == '0);

  // R7
  narrow_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_o == CNT_MAX && !(valid_o && ack_i) |=> narrow_o == CNT_MAX);

  // R7
  wide_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_mode && wide_o == WIDE_MAX && !(valid_o && ack_i) |=> wide_o == WIDE_MAX);

  // R8
  xfer_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(st == XFER));
endmodule

// File: tb/sim_pixel_digitizer.sv
`timescale 1ns/1ps
module sim_pixel_digitizer;
  localparam int DEAD = 19;

  logic clk = 0, rst_n = 0;
  logic disc_i = 0, test_pulse_i = 0, test_en_i = 0, mask_i = 0;
  logic [3:0]  phase_i = 0;
  logic [13:0] gts_i = 0;
  logic shutter_i = 0, ack_i = 0;
  logic [1:0] mode_i = 0;
  logic valid_o;
  logic [13:0] wide_o;
  logic [9:0]  narrow_o;
  logic [3:0]  fine_o;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pixel_digitizer #(.DEAD_CYC(DEAD)) u0 (.*);

  function automatic int sat(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction
  function automatic int exp_fine(int ph);
    return 15 - ph;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    gts_i = gts_i + 14'd1;
    phase_i = 4'($urandom);
  endtask

  task automatic set_src(logic v);
    if (test_en_i) test_pulse_i = v; else disc_i = v;
  endtask

  task automatic do_ack();
    ack_i = 1; step(); ack_i = 0;
    chk(!valid_o && wide_o == 0 && narrow_o == 0 && fine_o == 0, "R10 ack clear", valid_o, 0);
  endtask

  // time-mode pulse, checks R2 R3 R4 R5 R8
  task automatic time_hit(logic [1:0] md, int width);
    int toa, ph, n;
    mode_i = md;
    step();
    ph = int'($urandom % 16);
    phase_i = 4'(ph);
    toa = int'(gts_i);
    set_src(1);
    for (int i = 0; i < width; i++) step();
    set_src(0);
    n = 0;
    while (!valid_o && n < 80) begin step(); n++; end
    chk(n == DEAD + 3, "R8 valid latency", n, DEAD + 3);
    chk(wide_o == 14'(toa), "R2 coarse time", wide_o, toa);
    chk(fine_o == 4'(exp_fine(ph)), "R3 fine time", fine_o, exp_fine(ph));
    if (md == 2'b00) chk(narrow_o == 10'(sat(width, 1023)), "R4 width", narrow_o, sat(width, 1023));
    else             chk(narrow_o == 0, "R5 time-only width", narrow_o, 0);
  endtask

  task automatic pulse(int w, int gap);
    set_src(1);
    for (int i = 0; i < w; i++) step();
    set_src(0);
    for (int i = 0; i < gap; i++) step();
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!valid_o && n < 80) begin step(); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt, sum, w, g;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1;
    step();
    chk(!valid_o && wide_o == 0 && narrow_o == 0 && fine_o == 0, "R10 reset state", valid_o, 0);

    // directed time modes
    time_hit(2'b00, 7);  do_ack();
    time_hit(2'b01, 12); do_ack();
    time_hit(2'b00, 1);  do_ack();

    // R1 mask
    mask_i = 1; mode_i = 0;
    pulse(5, 40);
    chk(!valid_o && wide_o == 0, "R1 masked", valid_o, 0);
    mask_i = 0;
    // R1 test pulse selected: disc ignored
    test_en_i = 1;
    disc_i = 1; repeat (5) step(); disc_i = 0; repeat (40) step();
    chk(!valid_o, "R1 disc ignored in test", valid_o, 0);
    time_hit(2'b00, 9); do_ack();
    test_en_i = 0;
    test_pulse_i = 1; repeat (5) step(); test_pulse_i = 0; repeat (40) step();
    chk(!valid_o, "R1 test pulse ignored", valid_o, 0);

    // R9 pending: hits ignored
    time_hit(2'b00, 4);
    pulse(3, 6);
    chk(valid_o && narrow_o == 4, "R9 pending ignore", narrow_o, 4);
    do_ack();

    // R10 collision of ack and new rising edge
    time_hit(2'b00, 5);
    set_src(1); step(); step();
    ack_i = 1; step(); ack_i = 0;
    chk(!valid_o && narrow_o == 0 && wide_o == 0, "R10 ack with edge", narrow_o, 0);
    repeat (10) step();
    set_src(0);
    repeat (40) step();
    chk(!valid_o && wide_o == 0, "R10 edge discarded", valid_o, 0);

    // R7 width saturation
    time_hit(2'b00, 1100); do_ack();

    // R6 counting mode
    mode_i = 2'b10;
    pulse(3, 6);
    shutter_i = 1; repeat (3) step();
    cnt = 0; sum = 0;
    for (int k = 0; k < 8; k++) begin
      w = 1 + int'($urandom % 6); g = 1 + int'($urandom % 4);
      pulse(w, g); cnt++; sum += w;
    end
    repeat (4) step();
    shutter_i = 0;
    wait_valid();
    chk(valid_o && narrow_o == 10'(cnt), "R6 hit count", narrow_o, cnt);
    chk(wide_o == 14'(sum), "R6 integrated width", wide_o, sum);
    chk(fine_o == 0, "R6 fine zero", fine_o, 0);
    do_ack();

    // R7 count saturation
    shutter_i = 1; repeat (3) step();
    for (int k = 0; k < 1030; k++) pulse(1, 1);
    repeat (4) step(); shutter_i = 0; wait_valid();
    chk(narrow_o == 1023, "R7 count sat", narrow_o, 1023);
    chk(wide_o == 1030, "R7 count width", wide_o, 1030);
    do_ack();
    shutter_i = 1; repeat (3) step();
    pulse(16500, 4);
    repeat (2) step(); shutter_i = 0; wait_valid();
    chk(wide_o == 16383, "R7 integrated sat", wide_o, 16383);
    chk(narrow_o == 1, "R6 single long pulse", narrow_o, 1);
    do_ack();

    // random time-mode mix
    for (int k = 0; k < 30; k++) begin
      test_en_i = 1'($urandom);
      time_hit(2'($urandom % 2), 1 + int'($urandom % 40));
      do_ack();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule